// File: doc/BRIEF.md
# Configurable Routing Multiplexer with Compact Select Storage

This block picks one of several equal-width data inputs and drives it onto a single output. Which input wins is held in a small configuration store that is loaded bit by bit over a serial chain (clock, enable, serial in, serial out). Chains of these blocks can be daisy-chained through the serial output so a whole routing fabric loads from one pin.

The data path is a balanced tree of 2-input selector cells, each passing its first input when its select is high. Two build options change the shape. One adds an extra input, placed just above the last data input, that carries a fixed value of all zeros or all ones. The other stores a binary index instead of a one-hot word, which shrinks the store from one bit per input to the base-2 logarithm of the input count, rounded up. A local decoder turns that index back into a one-hot select. The decoded one-hot select is brought out so the current routing can be read back.

New configuration bits are held in a shadow shift register while loading. The live select only picks them up after the enable drops, so the output never routes through a half-loaded pattern.

Top module: `route_mux`

## Requirements
- R1: After reset the stored configuration is all zeros. With the binary option this routes input 0 and the readback is one-hot bit 0 set. Without it the output is 0 and the readback is all zeros.
- R2: While the configuration enable is high, each clock shifts the serial input into the store, most significant bit first. The serial output always shows the current most significant stored bit, so a previous pattern leaves the chain MSB first.
- R3: While the configuration enable is high, the live select and the output routing do not change. The newly shifted pattern takes effect on the first clock edge at which the enable is low.
- R4: With the binary option, a stored index k below the total input count routes input k to the output and sets only bit k of the readback.
- R5: With the binary option, an index at or above the total input count drives the output to 0 and the readback to all zeros.
- R6: With the constant option on, the extra input has index equal to the number of data inputs. It drives every output bit to the chosen constant value.
- R7: Without the binary option, the stored word is the select itself. Bit i set alone routes input i, and the readback equals the stored word.
- R8: Without the binary option, a stored word that has zero or several bits set drives the output to 0.
- R9: The number of stored bits is ceil(log2(total inputs)) with the binary option and the total input count without it. Total inputs are the data inputs plus one when the constant option is on. This count is seen as the delay from serial in to serial out.
- R10: When no constant value is chosen, the extra input carries 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset of the store |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_si | input | 1 | Serial configuration input |
| cfg_so | output | 1 | Serial configuration output, MSB of the shadow store |
| din | input | N_IN*DW | Data inputs, input i at bits [i*DW +: DW] |
| dout | output | DW | Selected data |
| sel_onehot | output | N_IN+ADD_CONST | Decoded one-hot select readback |

## Verification
On every clock the embedded assertions check several things. The live select holds still while the enable is high. A one-hot select routes exactly its input, including the constant input. Any select that is not one-hot yields zero. In binary mode the decoded select never has more than one bit set.

Other behaviour needs the directed scenarios. These cover the MSB-first order of bits leaving the chain, the chain length in both storage styles, and the one-cycle commit after the enable falls. They also cover the reset routing in each style and the default constant of zero.

// File: rtl/route_mux_pkg.sv
package route_mux_pkg;

   // Number of configuration bits needed for a given total input count
   function automatic int cfg_bits(int n_tot, bit enc);
      return enc ? $clog2(n_tot) : n_tot;
   endfunction

endpackage

// File: rtl/route_mux_cell.sv
module route_mux_cell #(
   parameter int DW = 1
) (
   input  logic [DW-1:0] in0,
   input  logic [DW-1:0] in1,
   input  logic          sel,
   output logic [DW-1:0] out
);
   // Select high passes the first input
   assign out = sel ? in0 : in1;
endmodule

// File: rtl/route_mux_chain.sv
module route_mux_chain #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         si,
   output logic         so,
   output logic [W-1:0] act
);
   logic [W-1:0] shadow;
   logic [W-1:0] shadow_nxt;

   generate
      if (W == 1) begin : g_one
         assign shadow_nxt = si;
      end else begin : g_many
         assign shadow_nxt = {shadow[W-2:0], si};
      end
   endgenerate

   assign so = shadow[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         act    <= '0;
      end else if (en) begin
         shadow <= shadow_nxt;
      end else begin
         act    <= shadow;
      end
   end

   // R3
   act_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (act == $past(act)));

endmodule

// File: rtl/route_mux_decode.sv
module route_mux_decode #(
   parameter int  NTOT    = 4,
   parameter bit  USE_ENC = 1'b1,
   parameter int  CW      = 2
) (
   input  logic [CW-1:0]   code,
   output logic [NTOT-1:0] onehot
);
   generate
      if (USE_ENC) begin : g_bin
         always_comb begin
            for (int i = 0; i < NTOT; i++) begin
               onehot[i] = (int'(code) == i);
            end
         end
      end else begin : g_raw
         if (CW != NTOT) begin : g_bad_w
            $error("route_mux_decode: raw width must equal input count");
         end
         assign onehot = code[NTOT-1:0];
      end
   endgenerate
endmodule

// File: rtl/route_mux_tree.sv
module route_mux_tree #(
   parameter int N  = 4,
   parameter int DW = 1
) (
   input  logic [N*DW-1:0] leaves,
   input  logic [N-1:0]    sel,
   output logic [DW-1:0]   y
);
   localparam int LVL = $clog2(N);
   localparam int P   = 1 << LVL;

   // Heap layout: node 1 is the root, leaves at P..2P-1
   logic [DW-1:0] nd [1:2*P-1];
   logic          na [1:2*P-1];
   logic          sel_ok;

   generate
      for (genvar i = 0; i < P; i++) begin : g_leaf
         if (i < N) begin : g_real
            assign nd[P+i] = leaves[i*DW +: DW];
            assign na[P+i] = sel[i];
         end else begin : g_pad
            assign nd[P+i] = '0;
            assign na[P+i] = 1'b0;
         end
      end
      for (genvar k = 1; k < P; k++) begin : g_node
         route_mux_cell #(.DW(DW)) u_cell (
            .in0 (nd[2*k]),
            .in1 (nd[2*k+1]),
            .sel (na[2*k]),
            .out (nd[k])
         );
         assign na[k] = na[2*k] | na[2*k+1];
      end
   endgenerate

   assign sel_ok = (sel != '0) &&
                   ((sel & (sel - {{(N-1){1'b0}}, 1'b1})) == '0);
   assign y = (sel_ok && na[1]) ? nd[1] : '0;
endmodule

// File: rtl/route_mux.sv
module route_mux
   import route_mux_pkg::*;
#(
   parameter int N_IN      = 4,
   parameter int DW        = 1,
   parameter bit ADD_CONST = 1'b0,
   parameter bit CONST_VAL = 1'b0,
   parameter bit USE_ENC   = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_en,
   input  logic                        cfg_si,
   output logic                        cfg_so,
   input  logic [N_IN*DW-1:0]          din,
   output logic [DW-1:0]               dout,
   output logic [N_IN+ADD_CONST-1:0]   sel_onehot
);
   localparam int NTOT  = N_IN + int'(ADD_CONST);
   localparam int CFG_W = cfg_bits(NTOT, USE_ENC);

   generate
      if (N_IN < 2) begin : g_chk_n
         $error("route_mux: N_IN must be at least 2");
      end
      if (DW < 1) begin : g_chk_dw
         $error("route_mux: DW must be at least 1");
      end
   endgenerate

   logic [CFG_W-1:0]   cfg_act;
   logic [NTOT*DW-1:0] all_in;

   route_mux_chain #(.W(CFG_W)) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg_en),
      .si    (cfg_si),
      .so    (cfg_so),
      .act   (cfg_act)
   );

   route_mux_decode #(.NTOT(NTOT), .USE_ENC(USE_ENC), .CW(CFG_W)) u_dec (
      .code   (cfg_act),
      .onehot (sel_onehot)
   );

   generate
      if (ADD_CONST) begin : g_const
         assign all_in = {{DW{CONST_VAL}}, din};
      end else begin : g_noconst
         assign all_in = din;
      end
   endgenerate

   route_mux_tree #(.N(NTOT), .DW(DW)) u_tree (
      .leaves (all_in),
      .sel    (sel_onehot),
      .y      (dout)
   );

   // R4 R7: a lone select bit routes exactly its input
   generate
      for (genvar i = 0; i < NTOT; i++) begin : g_route_chk
         route_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_onehot[i] && $onehot(sel_onehot)) |-> (dout == all_in[i*DW +: DW]));
      end
      if (ADD_CONST) begin : g_const_chk
         // R6
         const_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_onehot == (NTOT'(1) << N_IN)) |-> (dout == {DW{CONST_VAL}}));
      end
      if (USE_ENC) begin : g_dec_chk
         // R5
         dec_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(sel_onehot));
      end
   endgenerate

   // R5 R8
   bad_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$onehot(sel_onehot) |-> (dout == '0));

endmodule

// File: tb/tb_route_mux.sv
`timescale 1ns/1ps
module tb_route_mux;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   // Binary-index variant: 5 data inputs + constant 1, 3 stored bits
   logic        en_a = 1'b0, si_a = 1'b0;
   logic        so_a;
   logic [19:0] din_a;
   logic [3:0]  dout_a;
   logic [5:0]  oh_a;

   // Raw one-hot variant: 4 data inputs + default constant, 5 stored bits
   logic        en_b = 1'b0, si_b = 1'b0;
   logic        so_b;
   logic [15:0] din_b;
   logic [3:0]  dout_b;
   logic [4:0]  oh_b;

   route_mux #(.N_IN(5), .DW(4), .ADD_CONST(1'b1), .CONST_VAL(1'b1), .USE_ENC(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(en_a), .cfg_si(si_a), .cfg_so(so_a),
      .din(din_a), .dout(dout_a), .sel_onehot(oh_a));

   route_mux #(.N_IN(4), .DW(4), .ADD_CONST(1'b1), .USE_ENC(1'b0)) dut_raw (
      .clk(clk), .rst_n(rst_n), .cfg_en(en_b), .cfg_si(si_b), .cfg_so(so_b),
      .din(din_b), .dout(dout_b), .sel_onehot(oh_b));

   int cur_a = 0;
   logic [4:0] cur_b = '0;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_a(int c);
      if (c < 5) return din_a[c*4 +: 4];
      if (c == 5) return 4'hF;
      return 4'h0;
   endfunction

   function automatic logic [5:0] exp_oh_a(int c);
      return (c < 6) ? 6'(1 << c) : 6'h0;
   endfunction

   function automatic logic [3:0] exp_b(logic [4:0] w);
      if ($countones(w) != 1) return 4'h0;
      for (int i = 0; i < 4; i++) if (w[i]) return din_b[i*4 +: 4];
      return 4'h0;
   endfunction

   // Load a 3-bit index MSB first; checks chain output (R2 R9) and freeze (R3)
   task automatic load_a(int code);
      logic [2:0] prev = 3'(cur_a);
      logic [2:0] nw   = 3'(code);
      logic [3:0] hold = dout_a;
      for (int i = 2; i >= 0; i--) begin
         @(negedge clk);
         check("R3 frozen while shifting", dout_a, hold);
         check("R2 R9 serial out order", so_a, prev[i]);
         en_a = 1'b1;
         si_a = nw[i];
      end
      @(negedge clk);
      check("R3 frozen at last shift", dout_a, hold);
      check("R9 new pattern reached MSB", so_a, nw[2]);
      en_a = 1'b0;
      @(negedge clk);
      cur_a = code;
   endtask

   task automatic load_b(logic [4:0] w);
      logic [3:0] hold = dout_b;
      for (int i = 4; i >= 0; i--) begin
         @(negedge clk);
         check("R3 raw frozen while shifting", dout_b, hold);
         check("R2 R9 raw serial out order", so_b, cur_b[i]);
         en_b = 1'b1;
         si_b = w[i];
      end
      @(negedge clk);
      check("R3 raw frozen at last shift", dout_b, hold);
      en_b = 1'b0;
      @(negedge clk);
      cur_b = w;
   endtask

   task automatic t_reset();
      din_a = {4'h9, 4'h7, 4'h5, 4'h3, 4'h1};
      din_b = {4'hD, 4'hB, 4'h6, 4'h2};
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 binary reset routes input 0", dout_a, 4'h1);
      check("R1 binary reset readback", oh_a, 6'b000001);
      check("R1 raw reset output", dout_b, 4'h0);
      check("R1 raw reset readback", oh_b, 5'b00000);
   endtask

   task automatic t_binary_codes();
      for (int c = 1; c < 5; c++) begin
         load_a(c);
         check("R4 index routes input", dout_a, exp_a(c));
         check("R4 index readback", oh_a, exp_oh_a(c));
      end
      load_a(0);
      check("R4 index 0 after reload", dout_a, exp_a(0));
   endtask

   task automatic t_const_input();
      load_a(5);
      check("R6 constant one on extra input", dout_a, 4'hF);
      check("R6 constant readback", oh_a, 6'b100000);
   endtask

   task automatic t_out_of_range();
      load_a(6);
      check("R5 index 6 output zero", dout_a, 4'h0);
      check("R5 index 6 readback zero", oh_a, 6'h0);
      load_a(7);
      check("R5 index 7 output zero", dout_a, 4'h0);
      check("R5 index 7 readback zero", oh_a, 6'h0);
   endtask

   task automatic t_live_data();
      load_a(3);
      check("R4 before data change", dout_a, 4'h7);
      din_a[12 +: 4] = 4'hC;
      @(negedge clk);
      check("R4 routed data follows input", dout_a, 4'hC);
      din_a[4 +: 4] = 4'hE;
      @(negedge clk);
      check("R4 other input ignored", dout_a, 4'hC);
   endtask

   task automatic t_raw_onehot();
      for (int i = 0; i < 4; i++) begin
         load_b(5'(1 << i));
         check("R7 raw bit routes input", dout_b, exp_b(5'(1 << i)));
         check("R7 raw readback equals word", oh_b, 5'(1 << i));
      end
      load_b(5'b10000);
      check("R10 default constant is zero", dout_b, 4'h0);
      check("R10 constant readback", oh_b, 5'b10000);
   endtask

   task automatic t_raw_invalid();
      load_b(5'b00100);
      check("R7 raw setup", dout_b, 4'hB);
      load_b(5'b00011);
      check("R8 two bits set gives zero", dout_b, 4'h0);
      load_b(5'b11111);
      check("R8 all bits set gives zero", dout_b, 4'h0);
      load_b(5'b00000);
      check("R8 no bit set gives zero", dout_b, 4'h0);
   endtask

   initial begin
      t_reset();
      t_binary_codes();
      t_const_input();
      t_out_of_range();
      t_live_data();
      t_raw_onehot();
      t_raw_invalid();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end
endmodule